// File: doc/BRIEF.md
# Word Handshake Clock-Domain Crossing

This block carries one data word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. The source asks for a transfer with a single-cycle send strobe. The block copies the word into a holding register and reports busy. A four-phase request/acknowledge exchange then moves that word across. The request and the acknowledge are the only signals that pass through synchronizers. The data word itself crosses without a synchronizer. It is held constant in the source domain and is read in the destination domain only while the synchronized request says it is valid.

The destination presents each received word on a registered output and marks its arrival with a valid pulse one destination cycle long. The source may start the next transfer once busy has dropped. That happens only after the whole exchange has returned to rest, so every word arrives whole, in order, and exactly once, whatever the ratio of the two clocks.

Top module: `hs_word_xfer`

## Requirements
- R1: After reset, src_busy, dst_valid and dst_word are all zero.
- R2: A send strobe sampled while src_busy is low captures src_word, and src_busy is high in the next source cycle.
- R3: Each accepted word appears on dst_word unchanged, in the order it was sent, together with exactly one dst_valid pulse; no word is lost or repeated.
- R4: dst_word changes only in a cycle where dst_valid is high. Between transfers it holds the last delivered word, whatever happens on src_word.
- R5: The source raises its request only after the held word has been unchanged for at least one source cycle, and keeps the held word unchanged while the request is high.
- R6: The source lowers its request only after seeing the synchronized acknowledge high. src_busy stays high until the synchronized acknowledge has returned low, so the word has already been delivered when src_busy falls.
- R7: The destination lowers its acknowledge only after seeing the synchronized request low, so back-to-back transfers each complete.
- R8: A send strobe while src_busy is high is ignored: the word on src_word at that time is never delivered.
- R9: dst_valid is never high for two consecutive destination cycles.
- R10: With destination clock periods from 0.4x to 3.4x the source period, src_busy clears within 64 source cycles of the send strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_send | input | 1 | One-cycle request to transfer src_word |
| src_word | input | WORD_W | Word to transfer, sampled with src_send |
| src_busy | output | 1 | High from an accepted send until the exchange is back at rest |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_word | output | WORD_W | Last word received |
| dst_valid | output | 1 | One-cycle pulse when dst_word takes a new word |

## Verification
The bench puts junk on src_word in every cycle after a send. A design that forwarded the live input, or read the bus before the request settled, would deliver a wrong or torn word. It also pulses send in the middle of a transfer. A design that did not ignore that strobe would overwrite the held word or deliver an extra item. Transfers run back to back across destination clocks faster than, equal to and slower than the source clock. A design that lowered its acknowledge too early or released busy before the acknowledge came back would lose, repeat or reorder words, and the scoreboard queue would expose this. A drifting dst_word between pulses and a valid pulse longer than one cycle are also flagged.

// File: rtl/hs_xfer_pkg.sv
`timescale 1ns/1ps
package hs_xfer_pkg;

    // Fewest flops a synchronizer chain may have.
    localparam int unsigned MIN_SYNC_STAGES = 2;

    // Source-side progress through one exchange.
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_SETTLE  = 2'd1,
        SRC_REQ     = 2'd2,
        SRC_RELEASE = 2'd3
    } src_state_e;

    // Destination-side progress through one exchange.
    typedef enum logic {
        DST_WAIT = 1'b0,
        DST_HOLD = 1'b1
    } dst_state_e;

    // Next source state from the current state and its two inputs.
    function automatic src_state_e src_next(src_state_e cur, logic send, logic ack_seen);
        src_state_e nxt;
        nxt = cur;
        unique case (cur)
            SRC_IDLE:    if (send)      nxt = SRC_SETTLE;
            SRC_SETTLE:                 nxt = SRC_REQ;
            SRC_REQ:     if (ack_seen)  nxt = SRC_RELEASE;
            SRC_RELEASE: if (!ack_seen) nxt = SRC_IDLE;
            default:                    nxt = SRC_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/hs_sync_chain.sv
`timescale 1ns/1ps
module hs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("hs_sync_chain needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/hs_src_ctrl.sv
`timescale 1ns/1ps
module hs_src_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [WORD_W-1:0] word_in,
    input  logic              ack_seen,
    output logic              busy,
    output logic              req,
    output logic [WORD_W-1:0] word_hold
);
    src_state_e        state_q, state_d;
    logic              req_q;
    logic [WORD_W-1:0] hold_q;

    always_comb state_d = src_next(state_q, send, ack_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_IDLE;
            req_q   <= 1'b0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            req_q   <= (state_d == SRC_REQ);
            if (state_q == SRC_IDLE && send) hold_q <= word_in;
        end
    end

    assign busy      = (state_q != SRC_IDLE);
    assign req       = req_q;
    assign word_hold = hold_q;

    // R5: the held word was already stable the cycle the request rises
    a_r5_req_after_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $stable(hold_q));
    // R5: the held word does not move while the request is high
    a_r5_hold_under_req: assert property (@(posedge clk) disable iff (rst)
        req_q |=> (!req_q || $stable(hold_q)));
    // R6: the request only falls after the synchronized acknowledge was seen
    a_r6_req_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q) |-> $past(ack_seen));
    // R8: a strobe while busy leaves the held word alone
    a_r8_busy_send_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && send) |=> $stable(hold_q));
endmodule

// File: rtl/hs_dst_ctrl.sv
`timescale 1ns/1ps
module hs_dst_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_seen,
    input  logic [WORD_W-1:0] word_hold,
    output logic              ack,
    output logic [WORD_W-1:0] word_out,
    output logic              valid
);
    dst_state_e        state_q;
    logic              ack_q;
    logic              valid_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DST_WAIT;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                DST_WAIT: if (req_seen) begin
                    word_q  <= word_hold;
                    valid_q <= 1'b1;
                    ack_q   <= 1'b1;
                    state_q <= DST_HOLD;
                end
                DST_HOLD: if (!req_seen) begin
                    ack_q   <= 1'b0;
                    state_q <= DST_WAIT;
                end
                default: state_q <= DST_WAIT;
            endcase
        end
    end

    assign ack      = ack_q;
    assign word_out = word_q;
    assign valid    = valid_q;

    // R9: the valid pulse lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    // R3: each pulse belongs to a fresh acknowledge
    a_r3_pulse_with_ack: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $rose(ack_q));
    // R4: the output word only moves with a pulse
    a_r4_word_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(word_q));
    // R7: the acknowledge only falls after the request was seen low
    a_r7_ack_drop_after_req: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_q) |-> !$past(req_seen));
endmodule

// File: rtl/hs_word_xfer.sv
`timescale 1ns/1ps
module hs_word_xfer
    import hs_xfer_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_send,
    input  logic [WORD_W-1:0] src_word,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic [WORD_W-1:0] dst_word,
    output logic              dst_valid
);
    logic              req_raw, req_seen;
    logic              ack_raw, ack_seen;
    logic [WORD_W-1:0] held_word;

    hs_src_ctrl #(.WORD_W(WORD_W)) src_i (
        .clk       (src_clk),
        .rst       (src_rst),
        .send      (src_send),
        .word_in   (src_word),
        .ack_seen  (ack_seen),
        .busy      (src_busy),
        .req       (req_raw),
        .word_hold (held_word)
    );

    hs_sync_chain #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (req_raw),
        .q   (req_seen)
    );

    hs_sync_chain #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk (src_clk),
        .rst (src_rst),
        .d   (ack_raw),
        .q   (ack_seen)
    );

    hs_dst_ctrl #(.WORD_W(WORD_W)) dst_i (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_seen  (req_seen),
        .word_hold (held_word),
        .ack       (ack_raw),
        .word_out  (dst_word),
        .valid     (dst_valid)
    );
endmodule

// File: tb/hs_word_xfer_tb_top.sv
`timescale 1ns/1ps
module hs_word_xfer_tb_top;
    localparam int W = 16;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst = 1'b1;
    logic         dst_rst = 1'b1;
    logic         src_send = 1'b0;
    logic [W-1:0] src_word = '0;
    logic         src_busy;
    logic [W-1:0] dst_word;
    logic         dst_valid;

    realtime dst_half = 5.0;
    int      checks = 0;
    int      errors = 0;
    int      sent = 0;
    int      rcvd = 0;
    int      cyc = 0;
    bit      mon_on = 1'b0;
    bit      done = 1'b0;
    bit      word_moved = 1'b0;
    bit      prev_valid = 1'b0;
    logic [W-1:0] prev_word = '0;
    logic [W-1:0] exp_q[$];

    hs_word_xfer #(.WORD_W(W)) dut_i (
        .src_clk   (src_clk),
        .src_rst   (src_rst),
        .src_send  (src_send),
        .src_word  (src_word),
        .src_busy  (src_busy),
        .dst_clk   (dst_clk),
        .dst_rst   (dst_rst),
        .dst_word  (dst_word),
        .dst_valid (dst_valid)
    );

    always #5 src_clk = ~src_clk;
    always begin
        #(dst_half);
        dst_clk = ~dst_clk;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every pulse
    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (!dst_valid && dst_word !== prev_word) word_moved = 1'b1;
            if (dst_valid) begin
                chk(!word_moved, "R4 word moved without pulse", 32'(dst_word), 32'(prev_word));
                word_moved = 1'b0;
                chk(!prev_valid, "R9 valid longer than one cycle", 32'(prev_valid), 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected word", 32'(dst_word), 32'hFFFF_FFFF);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(dst_word === e, "R3 word mismatch", 32'(dst_word), 32'(e));
                end
                rcvd++;
            end
            prev_valid = dst_valid;
            prev_word  = dst_word;
        end
    end

    // Driver: one transfer, optional strobe during busy
    task automatic send_word(input logic [W-1:0] w, input bit poke);
        int n;
        @(negedge src_clk);
        while (src_busy) @(negedge src_clk);
        src_send = 1'b1;
        src_word = w;
        exp_q.push_back(w);
        sent++;
        @(negedge src_clk);
        src_send = 1'b0;
        src_word = W'($urandom);
        chk(src_busy === 1'b1, "R2 busy after send", 32'(src_busy), 32'd1);
        n = 1;
        while (src_busy && n < 200) begin
            if (poke && n == 3) begin
                src_send = 1'b1;
                src_word = ~w;  // R8: this word must never arrive
            end else begin
                src_send = 1'b0;
                src_word = W'($urandom);
            end
            @(negedge src_clk);
            n++;
        end
        src_send = 1'b0;
        chk(n <= 64, "R10 busy duration", 32'(n), 32'd64);
        chk(rcvd == sent, "R6 busy fell before delivery", 32'(rcvd), 32'(sent));
    endtask

    task automatic run_phase(input realtime half, input int base);
        dst_half = half;
        for (int i = 0; i < 6; i++) send_word(W'(base + i * 257), (i % 3) == 1);   // back to back, R7
        for (int i = 0; i < 4; i++) send_word(W'(16'h1 << (i * 4 + base % 4)), 1'b0);
        send_word(16'hAAAA, 1'b1);
        send_word(16'h5555, 1'b0);
        send_word(16'hFFFF, 1'b0);
        send_word(16'h0000, 1'b1);
        repeat (20) @(negedge src_clk);
        chk(exp_q.size() == 0, "R3 words outstanding", 32'(exp_q.size()), 32'd0);
        chk(rcvd == sent, "R8 delivered count", 32'(rcvd), 32'(sent));
    endtask

    always @(posedge src_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge src_clk);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        @(negedge src_clk);
        chk(src_busy === 1'b0, "R1 busy after reset", 32'(src_busy), 32'd0);
        chk(dst_valid === 1'b0, "R1 valid after reset", 32'(dst_valid), 32'd0);
        chk(dst_word === '0, "R1 word after reset", 32'(dst_word), 32'd0);
        prev_word = dst_word;
        mon_on = 1'b1;
        run_phase(5.0, 16'h0101);   // equal clocks
        run_phase(2.0, 16'h2300);   // destination faster
        run_phase(17.0, 16'h4C7E);  // destination slower
        run_phase(7.3, 16'h9001);   // unrelated ratio
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule